// File: doc/BRIEF.md
# Multi-channel interrupt source aggregator

This block collects the interrupt conditions of four serial channels and exposes them to a host as a small set of read-only registers at consecutive addresses. One register shows which channels want service. Two further registers hold a 12-bit field. In that field each channel gets a 3-bit code naming its most urgent pending source, chosen by a fixed priority. The last register is present in the address map but always reads zero.

Each channel supplies four raw source flags: line status error, receive data or timeout, transmit empty, and modem status. These flags are assumed to have passed the channel's own enables already. A device-level timer event, with its own enable, can only ever appear on channel 0. Register reads are combinational, so a read shows the current state of the sources with no delay. There is no clear-on-read: a pending condition goes away only when its source flag drops. An active-high summary interrupt is driven whenever any channel is pending. While reset is asserted, every register reads 0x00 and the summary interrupt is low, whatever the sources are doing.

Top module: `irq_src_aggregator`

## Requirements
- R1: The register space has four addresses, 0 to 3. Address 3 always reads 0x00.
- R2: While rst_n is low, every read returns 0x00 and irq_o is 0, even when sources are active.
- R3: In the register at address 0, bit n (n = 0..3) is 1 exactly when channel n has a pending source. Bits 7:4 always read 0.
- R4: A channel's pending bit is 1 exactly when its 3-bit code is non-zero. Repeated reads return the same value, and the bit clears only when that channel's sources drop.
- R5: Each channel's code names its highest-priority active source. Codes are 1 = line status (highest), 2 = receive data, 3 = transmit empty, 4 = modem status, 7 = timer (lowest). Code 0 means nothing is pending.
- R6: Code 7 appears only on channel 0, and only when tmr_evt and tmr_evt_en are both 1. With tmr_evt_en at 0 the timer event has no effect. Channels 1 to 3 never report 7.
- R7: The 12-bit code field holds channel 0 in bits 2:0, channel 1 in 5:3, channel 2 in 8:6 and channel 3 in 11:9. Address 1 returns field bits 7:0. Address 2 returns field bits 11:8 in its bits 3:0, with bits 7:4 zero.
- R8: irq_o is 1 exactly when at least one channel's pending bit is 1.
- R9: rd_data reflects rd_addr and the sources in the same cycle, with no register stage. When rd_en is 0, rd_data is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used by the embedded property checks |
| rst_n | input | 1 | Active-low reset; forces all reads and irq_o to zero |
| src_line | input | 4 | Per-channel line status error flag |
| src_rxdata | input | 4 | Per-channel receive data or timeout flag |
| src_txempty | input | 4 | Per-channel transmit empty flag |
| src_modem | input | 4 | Per-channel modem status flag |
| tmr_evt | input | 1 | Timer time-out event |
| tmr_evt_en | input | 1 | Device-level enable for the timer event |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 2 | Register address |
| rd_data | output | 8 | Read data |
| irq_o | output | 1 | Summary interrupt, OR of all pending bits |

## Verification
Two things can happen on the same cycle. One is priority resolution among several sources on one channel. The other is the timer event arriving on channel 0 while a higher-priority channel-0 source is also active, which is also the cycle in which the enable-gating matters. The bench drives all 32 combinations of channel-0 flags, with the timer enable on and off, while the other channels carry rotating patterns. Each read is judged against a reference model that resolves the code with its own priority chain, so a lost priority, a leaked code 7, or a misplaced field bit shows up in the read data of that cycle.

// File: rtl/irq_aggr_pkg.sv
package irq_aggr_pkg;

   localparam int CODE_W = 3;

   typedef enum logic [CODE_W-1:0] {
      SRC_NONE    = 3'd0,
      SRC_LINE    = 3'd1,
      SRC_RXDATA  = 3'd2,
      SRC_TXEMPTY = 3'd3,
      SRC_MODEM   = 3'd4,
      SRC_TIMER   = 3'd7
   } src_code_e;

   typedef struct packed {
      logic line;
      logic rxdata;
      logic txempty;
      logic modem;
      logic timer;
   } src_flags_t;

endpackage

// File: rtl/irq_chan_encoder.sv
module irq_chan_encoder
   import irq_aggr_pkg::*;
#(
   parameter bit HAS_TIMER = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  src_flags_t flags,
   output src_code_e  code,
   output logic       pend
);

   logic timer_ok;

   generate
      if (HAS_TIMER) begin : g_timer
         assign timer_ok = flags.timer;
      end else begin : g_no_timer
         assign timer_ok = 1'b0;
         // R6: a channel without the timer never sees a timer flag nor reports it
         assert_no_timer_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !flags.timer && (code != SRC_TIMER))
            else $error("timer code on non-timer channel");
      end
   endgenerate

   // fixed priority chain, line status first, timer last
   always_comb begin
      code = SRC_NONE;
      if (flags.line)
         code = SRC_LINE;
      else if (flags.rxdata)
         code = SRC_RXDATA;
      else if (flags.txempty)
         code = SRC_TXEMPTY;
      else if (flags.modem)
         code = SRC_MODEM;
      else if (timer_ok)
         code = SRC_TIMER;
   end

   assign pend = flags.line | flags.rxdata | flags.txempty | flags.modem | timer_ok;

   assert_line_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
      flags.line |-> (code == SRC_LINE))
      else $error("line status not given top priority");

   assert_modem_over_timer_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (flags.modem && !flags.line && !flags.rxdata && !flags.txempty) |-> (code == SRC_MODEM))
      else $error("modem status lost priority");

endmodule

// File: rtl/irq_reg_map.sv
module irq_reg_map #(
   parameter int NUM_CH   = 4,
   parameter int CODE_W   = 3,
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 2,
   parameter int NUM_REGS = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     rd_en,
   input  logic [ADDR_W-1:0]        rd_addr,
   input  logic [NUM_CH-1:0]        pend_vec,
   input  logic [NUM_CH*CODE_W-1:0] code_vec,
   output logic [DATA_W-1:0]        rd_data
);

   localparam int FIELD_W    = NUM_CH * CODE_W;
   localparam int CODE_BYTES = (FIELD_W + DATA_W - 1) / DATA_W;
   localparam int SPAN       = 2 ** ADDR_W;
   localparam int LAST_USED  = CODE_BYTES;

   generate
      if (NUM_CH > DATA_W) begin : g_bad_width
         $error("irq_reg_map: more channels than indicator bits");
      end
      if (NUM_REGS < 1 + CODE_BYTES) begin : g_bad_regs
         $error("irq_reg_map: too few registers for the code field");
      end
      if (NUM_REGS > SPAN) begin : g_bad_addr
         $error("irq_reg_map: address too narrow for register count");
      end
   endgenerate

   logic [DATA_W-1:0]            ind_byte;
   logic [CODE_BYTES*DATA_W-1:0] field_pad;
   logic [DATA_W-1:0]            regs [SPAN];

   always_comb begin
      ind_byte                = '0;
      ind_byte[NUM_CH-1:0]    = pend_vec;
      field_pad               = '0;
      field_pad[FIELD_W-1:0]  = code_vec;
   end

   generate
      for (genvar r = 0; r < SPAN; r++) begin : g_reg
         if (r == 0) begin : g_ind
            assign regs[r] = ind_byte;
         end else if (r <= CODE_BYTES) begin : g_code
            assign regs[r] = field_pad[(r-1)*DATA_W +: DATA_W];
         end else begin : g_zero
            assign regs[r] = '0;
         end
      end
   endgenerate

   assign rd_data = rd_en ? regs[rd_addr] : '0;

   assert_idle_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |-> (rd_data == '0))
      else $error("read data not zero without strobe");

   assert_unused_reg_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (int'(rd_addr) > LAST_USED)) |-> (rd_data == '0))
      else $error("unused register returned data");

   generate
      if (NUM_CH < DATA_W) begin : g_rsvd_chk
         assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && (rd_addr == '0)) |-> (rd_data[DATA_W-1:NUM_CH] == '0))
            else $error("reserved indicator bits set");
      end
   endgenerate

endmodule

// File: rtl/irq_src_aggregator.sv
module irq_src_aggregator
   import irq_aggr_pkg::*;
#(
   parameter int NUM_CH   = 4,
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 2,
   parameter int NUM_REGS = 4,
   parameter int TIMER_CH = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] src_line,
   input  logic [NUM_CH-1:0] src_rxdata,
   input  logic [NUM_CH-1:0] src_txempty,
   input  logic [NUM_CH-1:0] src_modem,
   input  logic              tmr_evt,
   input  logic              tmr_evt_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq_o
);

   localparam int FIELD_W = NUM_CH * CODE_W;

   generate
      if (TIMER_CH < 0 || TIMER_CH >= NUM_CH) begin : g_bad_timer
         $error("irq_src_aggregator: timer channel out of range");
      end
   endgenerate

   logic [NUM_CH-1:0]  pend_vec;
   logic [FIELD_W-1:0] code_vec;

   generate
      for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
         src_flags_t fl;
         src_code_e  code_ch;

         // reset forces every source quiet so all reads are zero
         always_comb begin
            fl.line    = rst_n & src_line[ch];
            fl.rxdata  = rst_n & src_rxdata[ch];
            fl.txempty = rst_n & src_txempty[ch];
            fl.modem   = rst_n & src_modem[ch];
            fl.timer   = (ch == TIMER_CH) ? (rst_n & tmr_evt & tmr_evt_en) : 1'b0;
         end

         irq_chan_encoder #(
            .HAS_TIMER(ch == TIMER_CH)
         ) u_enc (
            .clk   (clk),
            .rst_n (rst_n),
            .flags (fl),
            .code  (code_ch),
            .pend  (pend_vec[ch])
         );

         assign code_vec[ch*CODE_W +: CODE_W] = code_ch;

         assert_pend_matches_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
            pend_vec[ch] == (code_vec[ch*CODE_W +: CODE_W] != '0))
            else $error("pending bit disagrees with code");
      end
   endgenerate

   irq_reg_map #(
      .NUM_CH   (NUM_CH),
      .CODE_W   (CODE_W),
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W),
      .NUM_REGS (NUM_REGS)
   ) u_map (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en    (rd_en),
      .rd_addr  (rd_addr),
      .pend_vec (pend_vec),
      .code_vec (code_vec),
      .rd_data  (rd_data)
   );

   assign irq_o = |pend_vec;

   assert_irq_follows_ind_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (rd_addr == '0)) |-> (irq_o == (|rd_data)))
      else $error("summary interrupt disagrees with indicator register");

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_quiet_R2: assert (!irq_o && (rd_data == '0))
            else $error("output active during reset");
      end
   end

endmodule

// File: tb/irq_src_aggregator_bench.sv
module irq_src_aggregator_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] b_line = '0, b_rx = '0, b_tx = '0, b_mdm = '0;
   logic       b_tmr = 1'b0, b_tmr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [1:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       irq_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [7:0] q_data [$];
   logic       q_irq  [$];
   string      q_tag  [$];

   always #4 clk = ~clk;

   irq_src_aggregator u_irq_src_aggregator (
      .clk(clk), .rst_n(rst_n),
      .src_line(b_line), .src_rxdata(b_rx), .src_txempty(b_tx), .src_modem(b_mdm),
      .tmr_evt(b_tmr), .tmr_evt_en(b_tmr_en),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o)
   );

   // reference: priority 1 line, 2 rx, 3 tx, 4 modem, 7 timer (ch0 only)
   function automatic logic [2:0] ref_code(int ch);
      if (!rst_n) return 3'd0;
      if (b_line[ch]) return 3'd1;
      if (b_rx[ch])   return 3'd2;
      if (b_tx[ch])   return 3'd3;
      if (b_mdm[ch])  return 3'd4;
      if (ch == 0 && b_tmr && b_tmr_en) return 3'd7;
      return 3'd0;
   endfunction

   function automatic logic [11:0] ref_field();
      logic [11:0] f = '0;
      for (int ch = 0; ch < 4; ch++) f[ch*3 +: 3] = ref_code(ch);
      return f;
   endfunction

   function automatic logic [3:0] ref_pend();
      logic [3:0] p;
      for (int ch = 0; ch < 4; ch++) p[ch] = (ref_code(ch) != 3'd0);
      return p;
   endfunction

   function automatic logic [7:0] ref_reg(logic [1:0] a, logic en);
      logic [11:0] f = ref_field();
      if (!en) return 8'h00;
      case (a)
         2'd0:    return {4'h0, ref_pend()};
         2'd1:    return f[7:0];
         2'd2:    return {4'h0, f[11:8]};
         default: return 8'h00;
      endcase
   endfunction

   task automatic push_exp(logic [7:0] d, string tag);
      q_data.push_back(d);
      q_irq.push_back(|ref_pend());
      q_tag.push_back(tag);
   endtask

   task automatic rd(logic [1:0] a, string tag);
      @(negedge clk);
      rd_en   = 1'b1;
      rd_addr = a;
      push_exp(ref_reg(a, 1'b1), tag);
   endtask

   task automatic rd_idle(logic [1:0] a, string tag);
      @(negedge clk);
      rd_en   = 1'b0;
      rd_addr = a;
      push_exp(8'h00, tag);
   endtask

   task automatic set_src(logic [3:0] l, logic [3:0] r, logic [3:0] t, logic [3:0] m,
                          logic tm, logic tme);
      @(negedge clk);
      b_line = l; b_rx = r; b_tx = t; b_mdm = m; b_tmr = tm; b_tmr_en = tme;
   endtask

   // monitor: pops one expected item per rising edge
   always @(posedge clk) begin
      if (q_data.size() > 0) begin
         logic [7:0] ed;
         logic       ei;
         string      tg;
         ed = q_data.pop_front();
         ei = q_irq.pop_front();
         tg = q_tag.pop_front();
         checks++;
         if (rd_data !== ed || irq_o !== ei) begin
            errors++;
            $display("FAIL %s: actual data=%02h irq=%0b expected data=%02h irq=%0b",
                     tg, rd_data, irq_o, ed, ei);
         end
      end
   end

   initial begin
      // R2: sources active during reset are invisible
      b_line = 4'hF; b_rx = 4'hF; b_tmr = 1'b1; b_tmr_en = 1'b1;
      for (int a = 0; a < 4; a++) rd(2'(a), "R2 reset read");
      @(negedge clk);
      rst_n = 1'b1;

      // R1, R3: everything active, addr 3 and reserved bits zero
      set_src(4'hF, 4'hF, 4'hF, 4'hF, 1'b1, 1'b1);
      rd(2'd0, "R3 indicator all pending");
      rd(2'd3, "R1 address 3 reads zero");

      // R7: distinct code per channel
      set_src(4'b0001, 4'b0010, 4'b0100, 4'b1000, 1'b0, 1'b0);
      rd(2'd1, "R7 field low byte");
      rd(2'd2, "R7 field high byte");
      rd(2'd0, "R3 indicator distinct");

      // R6: timer on channel 0 only, enable gating
      set_src(4'h0, 4'h0, 4'h0, 4'h0, 1'b1, 1'b1);
      rd(2'd1, "R6 timer code ch0");
      rd(2'd0, "R8 timer drives irq");
      set_src(4'h0, 4'h0, 4'h0, 4'h0, 1'b1, 1'b0);
      rd(2'd1, "R6 timer masked");
      rd(2'd0, "R8 irq low when masked");
      set_src(4'h0, 4'h0, 4'h0, 4'b0001, 1'b1, 1'b1);
      rd(2'd1, "R5 modem beats timer");

      // R4: no clear on read, clears when source drops
      set_src(4'h0, 4'b0100, 4'h0, 4'h0, 1'b0, 1'b0);
      rd(2'd0, "R4 first read");
      rd(2'd0, "R4 repeated read");
      rd(2'd1, "R4 code after reads");
      rd(2'd2, "R4 code ch2 held");
      set_src(4'h0, 4'h0, 4'h0, 4'h0, 1'b0, 1'b0);
      rd(2'd0, "R4 cleared by source");
      rd(2'd2, "R4 code cleared");

      // R9: strobe low gives zero, address change seen same cycle
      set_src(4'hA, 4'h5, 4'h0, 4'h0, 1'b0, 1'b0);
      rd_idle(2'd0, "R9 strobe low");
      rd(2'd0, "R9 immediate addr 0");
      rd(2'd1, "R9 immediate addr 1");

      // R5, R6: sweep ch0 flags with timer enable both ways
      for (int v = 0; v < 64; v++) begin
         set_src({v[1], v[2], v[3], v[0]},
                 {v[0], v[3], v[2], v[1]},
                 {v[3], v[1], v[0], v[2]},
                 {v[2], v[0], v[1], v[3]},
                 v[4], v[5]);
         rd(2'd1, "R5 sweep low byte");
         rd(2'd2, "R6 sweep high byte");
         rd(2'd0, "R8 sweep indicator");
      end

      @(negedge clk);
      rd_en = 1'b0;
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual run still busy, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule